// File: doc/BRIEF.md
# E1 Performance Error Counters with One-Second Snapshots

This block keeps the running error counts for an E1 receive path. The receive framer supplies five single-cycle strobes: CRC-4 block error, far-end E-bit error, bipolar violation, frame alignment signal error and PRBS pattern error. Each strobe advances its own counter by one.

When a counter reaches its all-ones value and counts again, it wraps to zero. The wrap sets a sticky overflow flag. A counter can also pulse an interrupt on every count and another on wrap, and each of these interrupts has its own enable bit.

A one-second timer counts frame pulses (one per 125 us frame). At the end of each second it copies four of the counters into snapshot registers and raises a second-status flag. A small register port lets software preset, clear and read the counters, snapshots, status and enables. Read data appears one cycle after the read strobe.

Top module: `e1_perf_counters`

## Requirements
- R1: After reset every counter and snapshot reads 0, the status register reads 0, all interrupt enables are 0, and `irq_vec_o` and `irq_o` are low.
- R2: Each strobe adds one to its counter. The counters are addressed as CRC at 0 (10 bits), E-bit at 1 (10 bits), BPV at 2 (16 bits), FAS at 3 (8 bits) and PRBS at 4 (8 bits). A read with `rd_en_i` at a clock edge places the addressed value, zero-extended, on `rdata_o` after that edge.
- R3: A write to addresses 0 to 4 loads the counter with the low bits of `wdata_i`. Writing 0 clears the counter.
- R4: A counter that counts from all ones goes to 0, not saturating. In the cycle after the wrap, overflow bit k of the status register (address 9) is set, where k is 0 for CRC, 1 for E-bit, 2 for BPV, 3 for FAS and 4 for PRBS.
- R5: A read of address 9 returns the overflow bits and then clears them. A wrap in the same cycle as that read leaves its bit set.
- R6: If enable bit 5+k of address 10 is set, a wrap of counter k pulses `irq_vec_o[5+k]` for one cycle, in the cycle after the wrapping count.
- R7: If enable bit k of address 10 is set, every count of counter k pulses `irq_vec_o[k]` for one cycle, in the cycle after the count. Bits whose enable is clear never pulse. `irq_o` pulses whenever any bit of `irq_vec_o` is high.
- R8: When a write to a counter and its strobe arrive in the same cycle, the counter takes the written value and the event is dropped. No toggle or wrap interrupt results.
- R9: On every FRAMES_PER_SEC-th frame pulse there is a second tick. At the tick, status bit 5 goes to 1 and, if enable bit 10 is set, `irq_vec_o[10]` pulses in the next cycle. Status bit 5 returns to 0 on the FRAMES_PER_SEC/2-th frame pulse after the tick.
- R10: At each tick, snapshot addresses 5 (CRC), 6 (E-bit), 7 (BPV) and 8 (FAS) take the counter values held just before that edge. The counters keep running, and the snapshots hold until the next tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_pulse_i | input | 1 | One pulse per received 125 us frame |
| crc_err_i | input | 1 | CRC-4 block error strobe |
| ebit_err_i | input | 1 | Far-end E-bit error strobe |
| bpv_err_i | input | 1 | Bipolar violation strobe |
| fas_err_i | input | 1 | Frame alignment signal error strobe |
| prbs_err_i | input | 1 | PRBS bit error strobe |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| irq_vec_o | output | 11 | Per-source interrupt pulses: count [4:0], wrap [9:5], second [10] |
| irq_o | output | 1 | OR of all interrupt pulses |

## Verification
A counter that skips or repeats a count shows up in the next read of that counter, and also in a missing or extra toggle pulse one cycle after the strobe. A wrong wrap shows up as a wrong read value, an overflow bit in the next status read, and a wrap interrupt one cycle after the count. An off-by-one in the frame divider moves the second interrupt by a whole cycle. A wrong snapshot edge changes the latched value by exactly the event that lands on the tick edge.

// File: rtl/e1pm_pkg.sv
package e1pm_pkg;
  localparam int NCNT     = 5;
  localparam int NLAT     = 4;
  localparam int NIRQ     = 2 * NCNT + 1;
  localparam int ADDR_W   = 4;
  localparam int IX_CRC   = 0;
  localparam int IX_EBIT  = 1;
  localparam int IX_BPV   = 2;
  localparam int IX_FAS   = 3;
  localparam int IX_PRBS  = 4;
  localparam logic [ADDR_W-1:0] A_LAT0   = 4'd5;
  localparam logic [ADDR_W-1:0] A_STATUS = 4'd9;
  localparam logic [ADDR_W-1:0] A_IEN    = 4'd10;
endpackage

// File: rtl/e1pm_counter.sv
module e1pm_counter #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         evt_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o,
  output logic         tgl_o,
  output logic         wrap_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o  <= '0;
      tgl_o  <= 1'b0;
      wrap_o <= 1'b0;
    end else begin
      tgl_o  <= 1'b0;
      wrap_o <= 1'b0;
      if (load_i) begin
        cnt_o <= load_val_i;
      end else if (evt_i) begin
        cnt_o  <= cnt_o + 1'b1;
        tgl_o  <= 1'b1;
        wrap_o <= &cnt_o;
      end
    end
  end
endmodule

// File: rtl/e1pm_second_timer.sv
module e1pm_second_timer #(
  parameter int FRAMES = 8000
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_pulse_i,
  output logic tick_o,
  output logic flag_o
);
  localparam int SW   = (FRAMES > 2) ? $clog2(FRAMES) : 2;
  localparam int HALF = FRAMES / 2;
  localparam logic [SW-1:0] LAST    = SW'(FRAMES - 1);
  localparam logic [SW-1:0] HALF_M1 = SW'(HALF - 1);

  logic [SW-1:0] fcnt_q;

  assign tick_o = frame_pulse_i && (fcnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      fcnt_q <= '0;
      flag_o <= 1'b0;
    end else if (frame_pulse_i) begin
      fcnt_q <= tick_o ? '0 : fcnt_q + 1'b1;
      if (tick_o)                  flag_o <= 1'b1;
      else if (fcnt_q == HALF_M1)  flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/e1_perf_counters.sv
module e1_perf_counters
  import e1pm_pkg::*;
#(
  parameter int DW             = 16,
  parameter int CRC_W          = 10,
  parameter int EBIT_W         = 10,
  parameter int BPV_W          = 16,
  parameter int FAS_W          = 8,
  parameter int PRBS_W         = 8,
  parameter int FRAMES_PER_SEC = 8000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                frame_pulse_i,
  input  logic                crc_err_i,
  input  logic                ebit_err_i,
  input  logic                bpv_err_i,
  input  logic                fas_err_i,
  input  logic                prbs_err_i,
  input  logic                wr_en_i,
  input  logic                rd_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [DW-1:0]       rdata_o,
  output logic [NIRQ-1:0]     irq_vec_o,
  output logic                irq_o
);
  localparam int CNT_W [NCNT] = '{CRC_W, EBIT_W, BPV_W, FAS_W, PRBS_W};

  logic [NCNT-1:0] evt;
  logic [NCNT-1:0] tgl_pls;
  logic [NCNT-1:0] wrap_pls;
  logic [DW-1:0]   cnt_val [NCNT];
  logic [DW-1:0]   lat_q   [NLAT];
  logic [NCNT-1:0] ovf_q;
  logic [NIRQ-1:0] ien_q;
  logic            sec_tick;
  logic            sec_flag;
  logic            stat_rd;
  logic [NIRQ-1:0] irq_next;

  assign evt = {prbs_err_i, fas_err_i, bpv_err_i, ebit_err_i, crc_err_i};

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    localparam int W = CNT_W[g];
    logic [W-1:0] c;
    e1pm_counter #(.W(W)) i_cnt (
      .clk        (clk),
      .rst        (rst),
      .evt_i      (evt[g]),
      .load_i     (wr_en_i && (addr_i == ADDR_W'(g))),
      .load_val_i (wdata_i[W-1:0]),
      .cnt_o      (c),
      .tgl_o      (tgl_pls[g]),
      .wrap_o     (wrap_pls[g])
    );
    assign cnt_val[g] = DW'(c);
  end

  e1pm_second_timer #(.FRAMES(FRAMES_PER_SEC)) i_sec (
    .clk           (clk),
    .rst           (rst),
    .frame_pulse_i (frame_pulse_i),
    .tick_o        (sec_tick),
    .flag_o        (sec_flag)
  );

  // snapshot registers
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NLAT; i++) lat_q[i] <= '0;
    end else if (sec_tick) begin
      for (int i = 0; i < NLAT; i++) lat_q[i] <= cnt_val[i];
    end
  end

  // sticky overflow, cleared by status read; a new wrap wins
  assign stat_rd = rd_en_i && (addr_i == A_STATUS);
  always_ff @(posedge clk) begin
    if (rst) ovf_q <= '0;
    else     ovf_q <= (stat_rd ? '0 : ovf_q) | wrap_pls;
  end

  // interrupt enables and pulses
  assign irq_next = {sec_tick, wrap_pls, tgl_pls} & ien_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q     <= '0;
      irq_vec_o <= '0;
      irq_o     <= 1'b0;
    end else begin
      if (wr_en_i && addr_i == A_IEN) ien_q <= wdata_i[NIRQ-1:0];
      irq_vec_o <= irq_next;
      irq_o     <= |irq_next;
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else if (rd_en_i) begin
      if (addr_i < ADDR_W'(NCNT))
        rdata_o <= cnt_val[addr_i[2:0]];
      else if (addr_i >= A_LAT0 && addr_i < A_LAT0 + ADDR_W'(NLAT))
        rdata_o <= lat_q[2'(addr_i - A_LAT0)];
      else if (addr_i == A_STATUS)
        rdata_o <= DW'({sec_flag, ovf_q});
      else if (addr_i == A_IEN)
        rdata_o <= DW'(ien_q);
      else
        rdata_o <= '0;
    end
  end
endmodule

// File: rtl/e1pm_checker.sv
module e1pm_checker #(
  parameter int DW   = 16,
  parameter int CW   = 10,
  parameter int NC   = 5,
  parameter int NI   = 11
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en_i,
  input logic [3:0]    addr_i,
  input logic [DW-1:0] wdata_i,
  input logic          crc_err_i,
  input logic [DW-1:0] crc_cnt,
  input logic [NC-1:0] wrap_pls,
  input logic [NC-1:0] ovf_q,
  input logic [NI-1:0] ien_q,
  input logic [NI-1:0] irq_vec_o,
  input logic          irq_o,
  input logic          sec_tick
);
  localparam logic [DW-1:0] CMASK = DW'((1 << CW) - 1);

  // R1
  reset_clean_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ovf_q == '0 && irq_vec_o == '0 && !irq_o));

  // R2
  crc_count_chk: assert property (@(posedge clk) disable iff (rst)
    (crc_err_i && !(wr_en_i && addr_i == 4'd0)) |=>
      crc_cnt == (($past(crc_cnt) + 1'b1) & CMASK));

  // R4
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (|wrap_pls) |=> ((ovf_q & $past(wrap_pls)) == $past(wrap_pls)));

  // R7
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_vec_o & ~$past(ien_q)) == '0);

  // R8
  write_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i == 4'd0) |=> crc_cnt == ($past(wdata_i) & CMASK));

  // R9
  sec_irq_chk: assert property (@(posedge clk) disable iff (rst)
    irq_vec_o[NI-1] |-> $past(sec_tick));
endmodule

bind e1_perf_counters e1pm_checker #(
  .DW(DW), .CW(CRC_W), .NC(e1pm_pkg::NCNT), .NI(e1pm_pkg::NIRQ)
) i_e1pm_checker (
  .clk       (clk),
  .rst       (rst),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .crc_err_i (crc_err_i),
  .crc_cnt   (cnt_val[0]),
  .wrap_pls  (wrap_pls),
  .ovf_q     (ovf_q),
  .ien_q     (ien_q),
  .irq_vec_o (irq_vec_o),
  .irq_o     (irq_o),
  .sec_tick  (sec_tick)
);

// File: tb/test_e1_perf_counters.sv
`timescale 1ns/1ps
module test_e1_perf_counters;
  localparam int FPS = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fp = 1'b0;
  logic [4:0]  err = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [10:0] irq_vec;
  logic        irq;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  e1_perf_counters #(.FRAMES_PER_SEC(FPS)) i_e1_perf_counters (
    .clk(clk), .rst(rst), .frame_pulse_i(fp),
    .crc_err_i(err[0]), .ebit_err_i(err[1]), .bpv_err_i(err[2]),
    .fas_err_i(err[3]), .prbs_err_i(err[4]),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_vec_o(irq_vec), .irq_o(irq)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [15:0] exp);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    check(req, rdata, exp);
  endtask

  task automatic pulse(input int idx, input int n);
    for (int i = 0; i < n; i++) begin
      err[idx] = 1'b1;
      @(negedge clk);
      err[idx] = 1'b0;
    end
  endtask

  task automatic frames(input int n);
    fp = 1'b1;
    repeat (n) @(negedge clk);
    fp = 1'b0;
  endtask

  task automatic t_reset;
    for (int a = 0; a < 11; a++) rd_chk("R1 reset regs", 4'(a), 16'h0);
    check("R1 irq_vec", {5'd0, irq_vec}, 16'h0);
    check("R1 irq", {15'd0, irq}, 16'h0);
  endtask

  task automatic t_count;
    pulse(0, 3); pulse(1, 2); pulse(2, 5); pulse(3, 4); pulse(4, 1);
    rd_chk("R2 crc", 4'd0, 16'd3);
    rd_chk("R2 ebit", 4'd1, 16'd2);
    rd_chk("R2 bpv", 4'd2, 16'd5);
    rd_chk("R2 fas", 4'd3, 16'd4);
    rd_chk("R2 prbs", 4'd4, 16'd1);
  endtask

  task automatic t_preset;
    wr(4'd0, 16'hFFFF);
    rd_chk("R3 crc preset low bits", 4'd0, 16'h03FF);
    wr(4'd2, 16'h1234);
    rd_chk("R3 bpv preset", 4'd2, 16'h1234);
    wr(4'd3, 16'h0);
    rd_chk("R3 fas clear", 4'd3, 16'h0);
  endtask

  task automatic t_wrap;
    pulse(0, 1);
    rd_chk("R4 crc wraps to 0", 4'd0, 16'h0);
    wr(4'd2, 16'hFFFF);
    pulse(2, 1);
    rd_chk("R4 bpv wraps to 0", 4'd2, 16'h0);
    rd_chk("R4 status crc+bpv", 4'd9, 16'h0005);
    rd_chk("R5 status cleared by read", 4'd9, 16'h0);
  endtask

  task automatic t_prbs_irq;
    wr(4'd10, 16'h0200);
    wr(4'd4, 16'h00FF);
    pulse(4, 1);
    check("R6 no irq in wrap cycle", {5'd0, irq_vec}, 16'h0);
    @(negedge clk);
    check("R6 prbs wrap irq", {5'd0, irq_vec}, 16'h0200);
    check("R7 irq_o or", {15'd0, irq}, 16'h1);
    @(negedge clk);
    check("R6 one cycle pulse", {5'd0, irq_vec}, 16'h0);
    rd_chk("R6 prbs count", 4'd4, 16'h0);
    rd_chk("R4 prbs ovf", 4'd9, 16'h0010);
  endtask

  task automatic t_toggle_irq;
    wr(4'd10, 16'h0004);
    pulse(2, 1);
    @(negedge clk);
    check("R7 bpv toggle irq", {5'd0, irq_vec}, 16'h0004);
    pulse(0, 1);
    @(negedge clk);
    check("R7 crc masked", {5'd0, irq_vec}, 16'h0);
    check("R7 irq_o low", {15'd0, irq}, 16'h0);
  endtask

  task automatic t_write_prio;
    err[0] = 1'b1;
    wr(4'd0, 16'd5);
    err[0] = 1'b0;
    rd_chk("R8 write beats event", 4'd0, 16'd5);
    pulse(0, 1);
    rd_chk("R8 counting resumes", 4'd0, 16'd6);
  endtask

  task automatic t_second;
    wr(4'd0, 16'd7); wr(4'd1, 16'd9); wr(4'd2, 16'd300); wr(4'd3, 16'd11);
    wr(4'd10, 16'h0400);
    fp = 1'b1;
    repeat (FPS - 1) @(negedge clk);
    check("R9 no tick early", {5'd0, irq_vec}, 16'h0);
    @(negedge clk);
    fp = 1'b0;
    @(negedge clk);
    check("R9 second irq", {5'd0, irq_vec}, 16'h0);
    rd_chk("R9 flag set", 4'd9, 16'h0020);
    rd_chk("R10 lat crc", 4'd5, 16'd7);
    rd_chk("R10 lat ebit", 4'd6, 16'd9);
    rd_chk("R10 lat bpv", 4'd7, 16'd300);
    rd_chk("R10 lat fas", 4'd8, 16'd11);
    pulse(0, 1);
    rd_chk("R10 counter keeps running", 4'd0, 16'd8);
    rd_chk("R10 snapshot holds", 4'd5, 16'd7);
    frames(FPS / 2 - 1);
    rd_chk("R9 flag still set", 4'd9, 16'h0020);
    frames(1);
    rd_chk("R9 flag cleared at half", 4'd9, 16'h0);
    fp = 1'b1;
    repeat (FPS / 2) @(negedge clk);
    fp = 1'b0;
    check("R9 second tick irq", {5'd0, irq_vec}, 16'h0400);
    rd_chk("R10 new snapshot", 4'd5, 16'd8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_count();
    t_preset();
    t_wrap();
    t_prbs_irq();
    t_toggle_irq();
    t_write_prio();
    t_second();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired got 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule